// File: doc/BRIEF.md
# I/O MMU Context Register Bank

This block is the software-visible register bank of an I/O memory management unit. It serves up to sixteen translation contexts and up to sixty-four micro-TLB ports. It sits on a simple 32-bit register bus that completes in a single cycle: a write strobe, an address and write data, plus combinational read data for whatever address is presented.

Each context holds the following registers:
- a control word, with translation enable, TLB flush and interrupt enable bits;
- a table control word;
- a 64-bit translation-table base, split into two words;
- a fault status word;
- a fault address, split into two words.

A TLB invalidation is modelled as a busy flag. The flag stays up for a fixed number of cycles after software requests a flush. Software polls it until it drops.

Faults come in through a dedicated injection port. Each fault names a context, a fault kind and a faulting address. The block records them and drives one combined interrupt line.

Each micro-TLB port holds the following:
- an enable bit;
- the number of the context it uses;
- an address-space identifier.

Top module: `iommu_ctxregs`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Context n (n < 8) sits at byte address 0x40·n; context n ≥ 8 sits at 0x800 + 0x40·(n−8). Within a context:
  - control is at +0x00;
  - table control is at +0x08;
  - table base low is at +0x10 and table base high is at +0x14;
  - fault status is at +0x20;
  - fault address low is at +0x30 and fault address high is at +0x34.
  Every other address, including the low image 0x200–0x2FF, reads 0 and ignores writes.
- R3: Control bit 0 (translation enable) and bit 2 (interrupt enable) are stored as written and read back in place.
- R4: Writing 1 to control bit 1 makes that bit read 1 for exactly FlushLat cycles, then 0. A new 1 written while busy restarts the count. Writing 0 there does not end a flush in progress.
- R5: Micro-TLB port p has its control word at 0x300 + 16p for p < 32, and at 0x600 + 16(p−32) otherwise. Its control word holds enable in bit 0 and the context number in bits 7:4; bit 1 (flush) always reads 0. The port's identifier word sits 8 bytes above its control word and keeps the low AsidW bits written.
- R6: A cycle with `faultValid` high and a nonzero `faultKind` ORs bits into the status of context `faultCtx`:
  - kind bit 3 (multiple hit) sets status bit 4;
  - kind bit 2 (walk abort) sets status bit 2;
  - kind bit 1 (permission) sets status bit 1;
  - kind bit 0 (translation) sets status bit 0.
  A kind of 0 changes nothing.
- R7: The fault address is captured only when the context's status was zero; later faults keep the first address.
- R8: A write to fault status ANDs the stored bits with the written value. Bits written 0 clear; bits written 1 are unchanged.
- R9: Whenever a context's status becomes zero, both of its fault-address words read 0.
- R10: `irq` is high exactly when some context has interrupt enable set and a nonzero fault status.
- R11: When a status write and a fault for the same context land in the same cycle, the write applies first and the fault bits are then ORed in. If the write leaves the status zero, the new fault address is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 12 | Register byte address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| faultValid | input | 1 | Fault report strobe |
| faultCtx | input | 4 | Context number of the fault |
| faultKind | input | 4 | Fault kind: 3 multi-hit, 2 walk abort, 1 permission, 0 translation |
| faultAddr | input | VaW (40) | Faulting I/O virtual address |
| irq | output | 1 | Combined fault interrupt |

## Verification
The bound checker watches, on every cycle, the causes behind changes of `irq` and of each flush-busy flag:
- `irq` rises only after a fault report or a register write, and falls only after a write.
- A flush starts only on a write with bit 1 set.
- An enabled context receiving a fault raises `irq` on the next cycle.

Other behaviour only shows up in the bench's scenarios:
- the exact flush length and its restart;
- first-address retention;
- the high-context window and the micro-TLB layout;
- clear-by-zero, and the zeroing of the address once status is cleared;
- same-cycle write-and-fault ordering.

The bench shows these by comparing read data and `irq` against a behavioural model every cycle.

// File: rtl/iommu_regs_pkg.sv
`timescale 1ns/1ps
package iommu_regs_pkg;
  localparam int AddrW = 12;

  localparam logic [5:0] OffCtrl = 6'h00;
  localparam logic [5:0] OffTcr  = 6'h08;
  localparam logic [5:0] OffTbLo = 6'h10;
  localparam logic [5:0] OffTbHi = 6'h14;
  localparam logic [5:0] OffStat = 6'h20;
  localparam logic [5:0] OffFaLo = 6'h30;
  localparam logic [5:0] OffFaHi = 6'h34;

  localparam logic [AddrW-1:0] PortLoBase = 12'h300;
  localparam logic [AddrW-1:0] PortHiBase = 12'h600;
  localparam logic [AddrW-1:0] PortSpan   = 12'h200;

  typedef enum logic [2:0] {
    CR_NONE, CR_CTRL, CR_TCR, CR_TBLO, CR_TBHI, CR_STAT, CR_FALO, CR_FAHI
  } ctxReg_e;

  typedef enum logic [1:0] { PR_NONE, PR_CTRL, PR_ASID } portReg_e;

  typedef struct packed {
    logic     wr;
    ctxReg_e  ctxReg;
    logic [3:0] ctxIdx;
    portReg_e portReg;
    logic [5:0] portIdx;
  } strobe_t;

  // fault kind {multi, abort, perm, trans} -> status bits {4,2,1,0}
  function automatic logic [4:0] kindToStat(input logic [3:0] k);
    return {k[3], 1'b0, k[2], k[1], k[0]};
  endfunction
endpackage

// File: rtl/iommu_ctxregs_dec.sv
`timescale 1ns/1ps
module iommu_ctxregs_dec
  import iommu_regs_pkg::*;
#(
  parameter int NumCtx   = 16,
  parameter int NumPorts = 64
) (
  input  logic             busWe,
  input  logic [AddrW-1:0] busAddr,
  output strobe_t          strb
);
  logic       ctxWin, portWin;
  logic [3:0] ctxIdx;
  logic [5:0] portIdx;
  logic [8:0] portOff;

  always_comb begin
    ctxWin  = 1'b0;
    ctxIdx  = '0;
    portWin = 1'b0;
    portIdx = '0;
    portOff = '0;
    if (busAddr[11:9] == 3'b000) begin
      ctxWin = 1'b1;
      ctxIdx = {1'b0, busAddr[8:6]};
    end else if (busAddr[11:9] == 3'b100) begin
      ctxWin = 1'b1;
      ctxIdx = {1'b1, busAddr[8:6]};
    end
    if (busAddr >= PortLoBase && busAddr < PortLoBase + PortSpan) begin
      portOff = 9'(busAddr - PortLoBase);
      portWin = 1'b1;
      portIdx = {1'b0, portOff[8:4]};
    end else if (busAddr >= PortHiBase && busAddr < PortHiBase + PortSpan) begin
      portOff = 9'(busAddr - PortHiBase);
      portWin = 1'b1;
      portIdx = {1'b1, portOff[8:4]};
    end

    strb.wr      = busWe;
    strb.ctxIdx  = ctxIdx;
    strb.portIdx = portIdx;
    strb.ctxReg  = CR_NONE;
    strb.portReg = PR_NONE;
    if (ctxWin && 32'(ctxIdx) < NumCtx) begin
      case (busAddr[5:0])
        OffCtrl: strb.ctxReg = CR_CTRL;
        OffTcr:  strb.ctxReg = CR_TCR;
        OffTbLo: strb.ctxReg = CR_TBLO;
        OffTbHi: strb.ctxReg = CR_TBHI;
        OffStat: strb.ctxReg = CR_STAT;
        OffFaLo: strb.ctxReg = CR_FALO;
        OffFaHi: strb.ctxReg = CR_FAHI;
        default: strb.ctxReg = CR_NONE;
      endcase
    end
    if (portWin && 32'(portIdx) < NumPorts) begin
      case (portOff[3:0])
        4'h0:    strb.portReg = PR_CTRL;
        4'h8:    strb.portReg = PR_ASID;
        default: strb.portReg = PR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/iommu_ctxregs_dp.sv
`timescale 1ns/1ps
module iommu_ctxregs_dp
  import iommu_regs_pkg::*;
#(
  parameter int NumCtx   = 16,
  parameter int NumPorts = 64,
  parameter int FlushLat = 4,
  parameter int VaW      = 40,
  parameter int AsidW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              faultValid,
  input  logic [3:0]        faultCtx,
  input  logic [3:0]        faultKind,
  input  logic [VaW-1:0]    faultAddr,
  output logic [NumCtx-1:0] flushBusy,
  output logic [NumCtx-1:0] intEn,
  output logic              irq
);
  localparam int CntW = $clog2(FlushLat + 1);
  localparam int HiW  = VaW - 32;

  logic [NumCtx-1:0] xlEn, ieBit, ctxSel, faultPend;
  logic [CntW-1:0]   flCnt  [NumCtx];
  logic [31:0]       tcr    [NumCtx];
  logic [31:0]       tbLo   [NumCtx];
  logic [31:0]       tbHi   [NumCtx];
  logic [4:0]        stat   [NumCtx];
  logic [4:0]        stAfter[NumCtx];
  logic [4:0]        stNew  [NumCtx];
  logic [31:0]       faLo   [NumCtx];
  logic [HiW-1:0]    faHi   [NumCtx];
  logic [NumPorts-1:0] portSel, pEn;
  logic [3:0]          pCtx [NumPorts];
  logic [AsidW-1:0]    pAsid[NumPorts];

  always_comb begin
    for (int c = 0; c < NumCtx; c++) begin
      ctxSel[c]  = strb.wr && strb.ctxReg != CR_NONE && strb.ctxIdx == 4'(c);
      stAfter[c] = (ctxSel[c] && strb.ctxReg == CR_STAT) ? (stat[c] & busWdata[4:0]) : stat[c];
      stNew[c]   = (faultValid && faultCtx == 4'(c)) ? kindToStat(faultKind) : 5'd0;
    end
    for (int p = 0; p < NumPorts; p++)
      portSel[p] = strb.wr && strb.portReg != PR_NONE && strb.portIdx == 6'(p);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xlEn <= '0;
      ieBit <= '0;
      pEn <= '0;
      for (int c = 0; c < NumCtx; c++) begin
        flCnt[c] <= '0; tcr[c] <= '0; tbLo[c] <= '0; tbHi[c] <= '0;
        stat[c] <= '0; faLo[c] <= '0; faHi[c] <= '0;
      end
      for (int p = 0; p < NumPorts; p++) begin
        pCtx[p] <= '0; pAsid[p] <= '0;
      end
    end else begin
      for (int c = 0; c < NumCtx; c++) begin
        if (ctxSel[c]) begin
          case (strb.ctxReg)
            CR_CTRL: begin xlEn[c] <= busWdata[0]; ieBit[c] <= busWdata[2]; end
            CR_TCR:  tcr[c]  <= busWdata;
            CR_TBLO: tbLo[c] <= busWdata;
            CR_TBHI: tbHi[c] <= busWdata;
            default: ;
          endcase
        end
        if (ctxSel[c] && strb.ctxReg == CR_CTRL && busWdata[1])
          flCnt[c] <= CntW'(FlushLat);
        else if (flCnt[c] != '0)
          flCnt[c] <= flCnt[c] - 1'b1;
        stat[c] <= stAfter[c] | stNew[c];
        if (stAfter[c] == 5'd0) begin
          if (stNew[c] != 5'd0) begin
            faLo[c] <= faultAddr[31:0];
            faHi[c] <= faultAddr[VaW-1:32];
          end else begin
            faLo[c] <= '0;
            faHi[c] <= '0;
          end
        end
      end
      for (int p = 0; p < NumPorts; p++) begin
        if (portSel[p] && strb.portReg == PR_CTRL) begin
          pEn[p]  <= busWdata[0];
          pCtx[p] <= busWdata[7:4];
        end
        if (portSel[p] && strb.portReg == PR_ASID)
          pAsid[p] <= busWdata[AsidW-1:0];
      end
    end
  end

  for (genvar c = 0; c < NumCtx; c++) begin : g_ctxOut
    assign flushBusy[c] = (flCnt[c] != '0);
    assign faultPend[c] = (stat[c] != 5'd0);
  end
  assign intEn = ieBit;
  assign irq   = |(ieBit & faultPend);

  always_comb begin
    busRdata = '0;
    case (strb.ctxReg)
      CR_CTRL: busRdata = {29'd0, ieBit[strb.ctxIdx], flushBusy[strb.ctxIdx], xlEn[strb.ctxIdx]};
      CR_TCR:  busRdata = tcr[strb.ctxIdx];
      CR_TBLO: busRdata = tbLo[strb.ctxIdx];
      CR_TBHI: busRdata = tbHi[strb.ctxIdx];
      CR_STAT: busRdata = {27'd0, stat[strb.ctxIdx]};
      CR_FALO: busRdata = faLo[strb.ctxIdx];
      CR_FAHI: busRdata = 32'(faHi[strb.ctxIdx]);
      default: ;
    endcase
    case (strb.portReg)
      PR_CTRL: busRdata = {24'd0, pCtx[strb.portIdx], 3'd0, pEn[strb.portIdx]};
      PR_ASID: busRdata = 32'(pAsid[strb.portIdx]);
      default: ;
    endcase
  end
endmodule

// File: rtl/iommu_ctxregs.sv
`timescale 1ns/1ps
module iommu_ctxregs
  import iommu_regs_pkg::*;
#(
  parameter int NumCtx   = 16,
  parameter int NumPorts = 64,
  parameter int FlushLat = 4,
  parameter int VaW      = 40,
  parameter int AsidW    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [AddrW-1:0] busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic             faultValid,
  input  logic [3:0]       faultCtx,
  input  logic [3:0]       faultKind,
  input  logic [VaW-1:0]   faultAddr,
  output logic             irq
);
  strobe_t           strb;
  logic [NumCtx-1:0] flushBusy;
  logic [NumCtx-1:0] intEn;

  iommu_ctxregs_dec #(.NumCtx(NumCtx), .NumPorts(NumPorts)) decI (
    .busWe(busWe), .busAddr(busAddr), .strb(strb)
  );

  iommu_ctxregs_dp #(
    .NumCtx(NumCtx), .NumPorts(NumPorts), .FlushLat(FlushLat), .VaW(VaW), .AsidW(AsidW)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .busRdata(busRdata),
    .faultValid(faultValid), .faultCtx(faultCtx), .faultKind(faultKind),
    .faultAddr(faultAddr), .flushBusy(flushBusy), .intEn(intEn), .irq(irq)
  );
endmodule

// File: rtl/iommu_ctxregs_chk.sv
`timescale 1ns/1ps
module iommu_ctxregs_chk #(
  parameter int NumCtx = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic              wdFlush,
  input logic              faultValid,
  input logic [3:0]        faultCtx,
  input logic [3:0]        faultKind,
  input logic              irq,
  input logic [NumCtx-1:0] flushBusy,
  input logic [NumCtx-1:0] intEn
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !irq);

  // R10
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(faultValid) || $past(busWe)));

  // R8
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busWe));

  // R6
  fault_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultKind != 4'd0 && intEn[faultCtx] && !busWe) |=> irq);

  for (genvar c = 0; c < NumCtx; c++) begin : g_flushChk
    // R4
    flush_start_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flushBusy[c]) |-> $past(busWe && wdFlush));
  end
endmodule

bind iommu_ctxregs iommu_ctxregs_chk #(.NumCtx(NumCtx)) chkI (
  .clk(clk), .rstN(rstN), .busWe(busWe), .wdFlush(busWdata[1]),
  .faultValid(faultValid), .faultCtx(faultCtx), .faultKind(faultKind),
  .irq(irq), .flushBusy(flushBusy), .intEn(intEn)
);

// File: tb/iommu_ctxregs_tb_top.sv
`timescale 1ns/1ps
module iommu_ctxregs_tb_top;
  localparam int FLUSH_LAT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        faultValid = 1'b0;
  logic [3:0]  faultCtx = '0;
  logic [3:0]  faultKind = '0;
  logic [39:0] faultAddr = '0;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iommu_ctxregs #(.FlushLat(FLUSH_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .faultValid(faultValid), .faultCtx(faultCtx),
    .faultKind(faultKind), .faultAddr(faultAddr), .irq(irq)
  );

  // behavioural reference model
  logic        mEn[16], mIe[16];
  int          mFl[16];
  logic [31:0] mTcr[16], mTbl[16], mTbh[16], mFal[16];
  logic [4:0]  mSt[16];
  logic [7:0]  mFah[16];
  logic        mPEn[64];
  logic [3:0]  mPCtx[64];
  logic [7:0]  mPAsid[64];

  function automatic int ctxOf(int a);
    if (a < 'h200) return a / 64;
    if (a >= 'h800 && a < 'hA00) return 8 + (a - 'h800) / 64;
    return -1;
  endfunction

  function automatic int portOf(int a);
    if (a >= 'h300 && a < 'h500) return (a - 'h300) / 16;
    if (a >= 'h600 && a < 'h800) return 32 + (a - 'h600) / 16;
    return -1;
  endfunction

  function automatic logic [31:0] mRead(int a);
    int c = ctxOf(a);
    int p = portOf(a);
    if (c >= 0) begin
      case (a % 64)
        'h00: return {29'd0, mIe[c], mFl[c] > 0, mEn[c]};
        'h08: return mTcr[c];
        'h10: return mTbl[c];
        'h14: return mTbh[c];
        'h20: return {27'd0, mSt[c]};
        'h30: return mFal[c];
        'h34: return {24'd0, mFah[c]};
        default: return 32'd0;
      endcase
    end
    if (p >= 0) begin
      if (a % 16 == 0) return {24'd0, mPCtx[p], 3'd0, mPEn[p]};
      if (a % 16 == 8) return {24'd0, mPAsid[p]};
    end
    return 32'd0;
  endfunction

  function automatic logic mIrq();
    for (int c = 0; c < 16; c++)
      if (mIe[c] && mSt[c] != 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tagOf(int a);
    int c = ctxOf(a);
    if (c >= 0) begin
      case (a % 64)
        'h00: return "R4";
        'h20: return "R8";
        'h30, 'h34: return "R9";
        default: return "R2";
      endcase
    end
    if (portOf(a) >= 0) return "R5";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 16; c++) begin
        mEn[c] = 0; mIe[c] = 0; mFl[c] = 0; mTcr[c] = 0; mTbl[c] = 0; mTbh[c] = 0;
        mSt[c] = 0; mFal[c] = 0; mFah[c] = 0;
      end
      for (int p = 0; p < 64; p++) begin
        mPEn[p] = 0; mPCtx[p] = 0; mPAsid[p] = 0;
      end
    end else begin
      int c, p;
      logic [4:0] nb;
      for (int k = 0; k < 16; k++) if (mFl[k] > 0) mFl[k]--;
      if (busWe) begin
        c = ctxOf(int'(busAddr));
        p = portOf(int'(busAddr));
        if (c >= 0) begin
          case (int'(busAddr) % 64)
            'h00: begin
              mEn[c] = busWdata[0]; mIe[c] = busWdata[2];
              if (busWdata[1]) mFl[c] = FLUSH_LAT;
            end
            'h08: mTcr[c] = busWdata;
            'h10: mTbl[c] = busWdata;
            'h14: mTbh[c] = busWdata;
            'h20: mSt[c] = mSt[c] & busWdata[4:0];
            default: ;
          endcase
        end
        if (p >= 0) begin
          if (int'(busAddr) % 16 == 0) begin mPEn[p] = busWdata[0]; mPCtx[p] = busWdata[7:4]; end
          if (int'(busAddr) % 16 == 8) mPAsid[p] = busWdata[7:0];
        end
      end
      if (faultValid) begin
        c = int'(faultCtx);
        nb = {faultKind[3], 1'b0, faultKind[2:0]};
        if (nb != 0 && mSt[c] == 0) begin
          mFal[c] = faultAddr[31:0]; mFah[c] = faultAddr[39:32];
        end
        mSt[c] = mSt[c] | nb;
      end
      for (int k = 0; k < 16; k++)
        if (mSt[k] == 0) begin mFal[k] = 0; mFah[k] = 0; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, before new stimulus is driven
  always @(negedge clk) begin
    if (started && rstN && !done) begin
      chk("R10", {31'd0, irq}, {31'd0, mIrq()});
      chk(tagOf(int'(busAddr)), busRdata, mRead(int'(busAddr)));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    busWe = 1; busAddr = a; busWdata = d; faultValid = 0;
  endtask

  task automatic inj(logic [3:0] c, logic [3:0] k, logic [39:0] fa);
    @(negedge clk); #1;
    busWe = 0; faultValid = 1; faultCtx = c; faultKind = k; faultAddr = fa;
  endtask

  task automatic wrInj(logic [11:0] a, logic [31:0] d, logic [3:0] c, logic [3:0] k, logic [39:0] fa);
    @(negedge clk); #1;
    busWe = 1; busAddr = a; busWdata = d;
    faultValid = 1; faultCtx = c; faultKind = k; faultAddr = fa;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      busWe = 0; faultValid = 0;
    end
  endtask

  task automatic rdChk(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    busWe = 0; faultValid = 0; busAddr = a;
    #1 chk(tag, busRdata, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    started = 1;

    // R1 reset state
    rdChk(12'h000, 32'h0, "R1");
    chk("R1", {31'd0, irq}, 32'h0);
    rdChk(12'h9E0, 32'h0, "R1");
    rdChk(12'h350, 32'h0, "R1");

    // R2 context layout, low window
    wr(12'h0C8, 32'h8000_0000);
    wr(12'h0D0, 32'h1234_5678);
    wr(12'h0D4, 32'h0000_00A5);
    rdChk(12'h0D0, 32'h1234_5678, "R2");
    rdChk(12'h0C8, 32'h8000_0000, "R2");
    // R2 high window for context 9, and the unmapped low image
    wr(12'h850, 32'hCAFE_F00D);
    rdChk(12'h850, 32'hCAFE_F00D, "R2");
    rdChk(12'h250, 32'h0, "R2");
    wr(12'h250, 32'hFFFF_FFFF);
    rdChk(12'h250, 32'h0, "R2");

    // R4 flush busy timing
    wr(12'h040, 32'h7);
    rdChk(12'h040, 32'h7, "R4");
    idle(FLUSH_LAT + 1);
    rdChk(12'h040, 32'h5, "R4");
    // R3 enable and interrupt enable stored independently
    wr(12'h040, 32'h4);
    rdChk(12'h040, 32'h4, "R3");

    // R4 restart while busy
    wr(12'h000, 32'h2);
    idle(2);
    wr(12'h000, 32'h2);
    rdChk(12'h000, 32'h2, "R4");
    idle(2);
    rdChk(12'h000, 32'h2, "R4");
    idle(FLUSH_LAT);
    rdChk(12'h000, 32'h0, "R4");
    // R4 writing 0 does not cancel
    wr(12'h000, 32'h2);
    wr(12'h000, 32'h0);
    rdChk(12'h000, 32'h2, "R4");
    idle(FLUSH_LAT);

    // R5 micro-TLB ports
    wr(12'h350, 32'h73);
    rdChk(12'h350, 32'h71, "R5");
    wr(12'h358, 32'h1AB);
    rdChk(12'h358, 32'hAB, "R5");
    wr(12'h680, 32'h21);
    rdChk(12'h680, 32'h21, "R5");
    wr(12'h688, 32'h5C);
    rdChk(12'h688, 32'h5C, "R5");
    wr(12'h4F0, 32'hF1);
    rdChk(12'h4F0, 32'hF1, "R5");
    rdChk(12'h340, 32'h0, "R5");

    // R6 R7 fault capture on context 1 (interrupt enabled)
    inj(4'd1, 4'b0001, 40'h12_8000_1000);
    rdChk(12'h060, 32'h01, "R6");
    chk("R10", {31'd0, irq}, 32'h1);
    rdChk(12'h070, 32'h8000_1000, "R7");
    rdChk(12'h074, 32'h12, "R7");
    inj(4'd1, 4'b1000, 40'h03_0000_0004);
    rdChk(12'h060, 32'h11, "R6");
    rdChk(12'h070, 32'h8000_1000, "R7");
    rdChk(12'h074, 32'h12, "R7");
    // R8 R9 clear by writing zero
    wr(12'h060, 32'h10);
    rdChk(12'h060, 32'h10, "R8");
    rdChk(12'h070, 32'h8000_1000, "R9");
    wr(12'h060, 32'h0);
    rdChk(12'h060, 32'h0, "R8");
    rdChk(12'h070, 32'h0, "R9");
    rdChk(12'h074, 32'h0, "R9");
    chk("R10", {31'd0, irq}, 32'h0);

    // R10 no interrupt without enable, then enable raises it
    inj(4'd3, 4'b0100, 40'h00_0000_0ABC);
    rdChk(12'h0E0, 32'h04, "R6");
    chk("R10", {31'd0, irq}, 32'h0);
    wr(12'h0C0, 32'h4);
    rdChk(12'h0E0, 32'h04, "R10");
    chk("R10", {31'd0, irq}, 32'h1);
    wr(12'h0E0, 32'h0);
    rdChk(12'h0E0, 32'h0, "R8");
    chk("R10", {31'd0, irq}, 32'h0);

    // R11 same-cycle clear and new fault
    wr(12'h080, 32'h4);
    inj(4'd2, 4'b0001, 40'h01_1111_1111);
    wrInj(12'h0A0, 32'h0, 4'd2, 4'b0010, 40'h00_2222_3333);
    rdChk(12'h0A0, 32'h02, "R11");
    rdChk(12'h0B0, 32'h2222_3333, "R11");
    rdChk(12'h0B4, 32'h0, "R11");
    chk("R10", {31'd0, irq}, 32'h1);
    wr(12'h0A0, 32'h0);

    // R6 zero kind is ignored
    inj(4'd4, 4'b0000, 40'hFF_FFFF_FFFF);
    rdChk(12'h120, 32'h0, "R6");
    rdChk(12'h130, 32'h0, "R6");

    // R2 highest context through the high window
    wr(12'h9C0, 32'h4);
    inj(4'd15, 4'b0010, 40'h55_0000_0777);
    rdChk(12'h9E0, 32'h02, "R2");
    rdChk(12'h9F0, 32'h777, "R2");
    rdChk(12'h9F4, 32'h55, "R2");
    chk("R10", {31'd0, irq}, 32'h1);
    wr(12'h9E0, 32'h0);
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule